// File: doc/BRIEF.md
# Four-Digit Decimal Register ALU

This block is the single-operand arithmetic unit of a decimal machine whose words are four BCD digits, each holding 0 to 9. It receives the instruction's function digit, its third digit, the current value of the addressed register and a value offered by an external input source. One clock later it returns the new register value, a write-enable for the register file, a request for an input or output transfer, and an illegal-instruction flag. Every arithmetic result is kept in the range 0 to 9999 by modulo-10000 arithmetic.

The unit clears, increments, decrements, negates (ten's complement) and shifts by one decimal digit in either direction. Two function codes ask for a transfer: the input code loads the offered value into the register, and the output code only signals that the register value is to be sent out. The transfer handshake and the register file are outside the block.

Top module: `dec_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is driven to zero after that edge.
- R2: When `valid_i` is high and `mid_i` is not zero, the next cycle shows `illegal_o`=1, `wr_en_o`=0, both transfer requests 0 and a zero result, whatever the function code.
- R3: With `mid_i`=0, function codes 8 to 15 give `illegal_o`=1, `wr_en_o`=0, no transfer request and a zero result.
- R4: Code 0 (input) raises `xfer_in_o`; if every nibble of `ext_i` is 0 to 9 the result is `ext_i` with `wr_en_o`=1, otherwise the value is rejected: `illegal_o`=1, `wr_en_o`=0, result zero.
- R5: Code 1 (output) raises `xfer_out_o`, keeps `wr_en_o` low and returns the operand unchanged on `result_o`.
- R6: Code 2 returns 0000 with `wr_en_o`=1.
- R7: Code 3 returns (r + 1) mod 10000, so 9999 becomes 0000.
- R8: Code 4 returns (r + 9999) mod 10000, so 0000 becomes 9999.
- R9: Code 5 returns (10000 − r) mod 10000, so 0000 stays 0000 and 9999 becomes 0001.
- R10: Code 6 returns (r × 10) mod 10000: every digit moves one place up, the top digit is lost and the lowest digit becomes 0.
- R11: Code 7 returns r / 10 truncated: every digit moves one place down and the top digit becomes 0.
- R12: `done_o` is high exactly in the cycle after a cycle with `valid_i` high; without a request, `done_o`, `wr_en_o`, both transfer requests and `illegal_o` are low. Digit k of every word sits in bits 4k+3:4k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation request in this cycle |
| code_i | input | 4 | Function digit of the instruction |
| mid_i | input | 4 | Third instruction digit, must be zero |
| operand_i | input | 4*DIGITS (16) | Current register value, BCD |
| ext_i | input | 4*DIGITS (16) | Value offered by the input source, BCD |
| done_o | output | 1 | Result of last cycle's request is present |
| result_o | output | 4*DIGITS (16) | New register value, BCD |
| wr_en_o | output | 1 | Register file should take `result_o` |
| xfer_in_o | output | 1 | Input transfer requested |
| xfer_out_o | output | 1 | Output transfer requested |
| illegal_o | output | 1 | Instruction or input value rejected |

## Verification
The bench builds the unit with its default of four digits, which keeps the whole word space of 10000 values small enough to sweep every arithmetic code over every operand, so each carry, borrow and dropped-digit case is reached. Input values are swept over all 10000 legal words and then over words with a nibble above nine. Every combination of a non-zero third digit with the legal codes, and every code from 8 upward, is applied against expectations computed with integer arithmetic.

// File: rtl/dec_alu_pkg.sv
// Shared types of the decimal register ALU.
// Assumes: words are packed BCD, digit k in bits 4k+3:4k.
package dec_alu_pkg;

    // Function digits of the one-register group.
    localparam logic [3:0] FN_IN  = 4'd0;
    localparam logic [3:0] FN_OUT = 4'd1;
    localparam logic [3:0] FN_CLR = 4'd2;
    localparam logic [3:0] FN_INC = 4'd3;
    localparam logic [3:0] FN_DEC = 4'd4;
    localparam logic [3:0] FN_NEG = 4'd5;
    localparam logic [3:0] FN_SHL = 4'd6;
    localparam logic [3:0] FN_SHR = 4'd7;

    // Which datapath value becomes the result.
    typedef enum logic [2:0] {
        SEL_ZERO = 3'd0,
        SEL_EXT  = 3'd1,
        SEL_PASS = 3'd2,
        SEL_INC  = 3'd3,
        SEL_DEC  = 3'd4,
        SEL_NEG  = 3'd5,
        SEL_SHL  = 3'd6,
        SEL_SHR  = 3'd7
    } res_sel_e;

    // Decoded control for one request.
    typedef struct packed {
        logic     wr;
        logic     x_in;
        logic     x_out;
        logic     bad;
        res_sel_e sel;
    } ctl_t;

endpackage

// File: rtl/dalu_bcd_valid.sv
// Reports whether every nibble of a packed BCD word is a decimal digit.
// Assumes: nothing about the input; any nibble above 9 clears ok_o.
module dalu_bcd_valid #(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] val_i,
    output logic         ok_o
);
    logic [DIGITS-1:0] dig_ok;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        // One flag per digit: nibble is 0..9.
        assign dig_ok[g] = (val_i[4*g +: 4] <= 4'd9);
    end

    assign ok_o = &dig_ok;
endmodule

// File: rtl/dalu_nines.sv
// Nine's complement of a packed BCD word, digit by digit.
// Assumes: input digits are 0..9.
module dalu_nines #(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] val_o
);
    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        // Each digit becomes 9 minus itself.
        assign val_o[4*g +: 4] = 4'd9 - val_i[4*g +: 4];
    end
endmodule

// File: rtl/dalu_bcd_incr.sv
// Adds one to a packed BCD word modulo 10^DIGITS with a digit carry chain.
// Assumes: input digits are 0..9; the carry out of the top digit is dropped.
module dalu_bcd_incr #(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] val_o
);
    logic [DIGITS:0] carry;

    assign carry[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        logic [3:0] d;
        assign d = val_i[4*g +: 4];
        // A carried-into 9 wraps to 0 and passes the carry on.
        assign carry[g+1] = carry[g] & (d == 4'd9);
        // Digit value after the carry is applied.
        assign val_o[4*g +: 4] = !carry[g]      ? d :
                                 (d == 4'd9)    ? 4'd0 :
                                                  4'(d + 4'd1);
    end
endmodule

// File: rtl/dalu_decode.sv
// Turns the function digit and third digit into the control for one request.
// Assumes: ext_ok_i already tells whether the offered input word is valid BCD.
module dalu_decode
    import dec_alu_pkg::*;
(
    input  logic [3:0] code_i,
    input  logic [3:0] mid_i,
    input  logic       ext_ok_i,
    output ctl_t       ctl_o
);
    // Decode: a non-zero third digit or a code of 8 or more is rejected.
    always_comb begin
        ctl_o     = '0;
        ctl_o.sel = SEL_ZERO;
        if (mid_i != 4'd0 || code_i[3]) begin
            ctl_o.bad = 1'b1;
        end else begin
            unique case (code_i)
                FN_IN: begin
                    ctl_o.x_in = 1'b1;
                    if (ext_ok_i) begin
                        ctl_o.wr  = 1'b1;
                        ctl_o.sel = SEL_EXT;
                    end else begin
                        ctl_o.bad = 1'b1;
                    end
                end
                FN_OUT: begin
                    ctl_o.x_out = 1'b1;
                    ctl_o.sel   = SEL_PASS;
                end
                FN_CLR: begin
                    ctl_o.wr  = 1'b1;
                    ctl_o.sel = SEL_ZERO;
                end
                FN_INC: begin
                    ctl_o.wr  = 1'b1;
                    ctl_o.sel = SEL_INC;
                end
                FN_DEC: begin
                    ctl_o.wr  = 1'b1;
                    ctl_o.sel = SEL_DEC;
                end
                FN_NEG: begin
                    ctl_o.wr  = 1'b1;
                    ctl_o.sel = SEL_NEG;
                end
                FN_SHL: begin
                    ctl_o.wr  = 1'b1;
                    ctl_o.sel = SEL_SHL;
                end
                FN_SHR: begin
                    ctl_o.wr  = 1'b1;
                    ctl_o.sel = SEL_SHR;
                end
                default: ctl_o.bad = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/dalu_datapath.sv
// Computes every candidate result from the operand and picks one.
// Negation is nine's complement plus one; decrement is the nine's
// complement of the negation, so one incrementer serves both.
// Assumes: operand digits are 0..9.
module dalu_datapath
    import dec_alu_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] operand_i,
    input  logic [W-1:0] ext_i,
    input  res_sel_e     sel_i,
    output logic [W-1:0] result_o
);
    logic [W-1:0] inc_v, nine_v, neg_v, dec_v, shl_v, shr_v;

    dalu_bcd_incr #(.DIGITS(DIGITS)) u_inc   (.val_i(operand_i), .val_o(inc_v));
    dalu_nines    #(.DIGITS(DIGITS)) u_nine  (.val_i(operand_i), .val_o(nine_v));
    dalu_bcd_incr #(.DIGITS(DIGITS)) u_negi  (.val_i(nine_v),    .val_o(neg_v));
    dalu_nines    #(.DIGITS(DIGITS)) u_decn  (.val_i(neg_v),     .val_o(dec_v));

    for (genvar g = 0; g < DIGITS; g++) begin : g_shift
        if (g == 0) begin : g_low
            // Lowest digit: zero fill going up, take the next digit going down.
            assign shl_v[3:0] = 4'd0;
        end else begin : g_up
            assign shl_v[4*g +: 4] = operand_i[4*(g-1) +: 4];
        end
        if (g == DIGITS - 1) begin : g_top
            // Top digit: zero fill going down.
            assign shr_v[4*g +: 4] = 4'd0;
        end else begin : g_dn
            assign shr_v[4*g +: 4] = operand_i[4*(g+1) +: 4];
        end
    end

    // Result select.
    always_comb begin
        unique case (sel_i)
            SEL_EXT:  result_o = ext_i;
            SEL_PASS: result_o = operand_i;
            SEL_INC:  result_o = inc_v;
            SEL_DEC:  result_o = dec_v;
            SEL_NEG:  result_o = neg_v;
            SEL_SHL:  result_o = shl_v;
            SEL_SHR:  result_o = shr_v;
            default:  result_o = '0;
        endcase
    end
endmodule

// File: rtl/dec_alu.sv
// Four-digit decimal register ALU, top level.
// Takes one request per cycle and registers its result and flags, so the
// answer appears one cycle after valid_i. Assumes operand_i is valid BCD;
// ext_i is checked and rejected when a nibble exceeds 9.
module dec_alu
    import dec_alu_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [3:0]   code_i,
    input  logic [3:0]   mid_i,
    input  logic [W-1:0] operand_i,
    input  logic [W-1:0] ext_i,
    output logic         done_o,
    output logic [W-1:0] result_o,
    output logic         wr_en_o,
    output logic         xfer_in_o,
    output logic         xfer_out_o,
    output logic         illegal_o
);
    logic         ext_ok;
    ctl_t         ctl;
    logic [W-1:0] res_next;

    dalu_bcd_valid #(.DIGITS(DIGITS)) u_extchk (
        .val_i (ext_i),
        .ok_o  (ext_ok)
    );

    dalu_decode u_dec (
        .code_i   (code_i),
        .mid_i    (mid_i),
        .ext_ok_i (ext_ok),
        .ctl_o    (ctl)
    );

    dalu_datapath #(.DIGITS(DIGITS)) u_dp (
        .operand_i (operand_i),
        .ext_i     (ext_i),
        .sel_i     (ctl.sel),
        .result_o  (res_next)
    );

    // Output register: flags pulse for one cycle per request, result holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o     <= 1'b0;
            result_o   <= '0;
            wr_en_o    <= 1'b0;
            xfer_in_o  <= 1'b0;
            xfer_out_o <= 1'b0;
            illegal_o  <= 1'b0;
        end else begin
            done_o     <= valid_i;
            wr_en_o    <= valid_i & ctl.wr;
            xfer_in_o  <= valid_i & ctl.x_in;
            xfer_out_o <= valid_i & ctl.x_out;
            illegal_o  <= valid_i & ctl.bad;
            if (valid_i) begin
                result_o <= res_next;
            end
        end
    end
endmodule

// File: rtl/dec_alu_checker.sv
// Property checks on the decimal register ALU ports, bound to every instance.
// Assumes: requests carry operands with valid BCD digits.
module dec_alu_checker #(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid_i,
    input logic [3:0]   code_i,
    input logic [3:0]   mid_i,
    input logic [W-1:0] operand_i,
    input logic         done_o,
    input logic [W-1:0] result_o,
    input logic         wr_en_o,
    input logic         xfer_in_o,
    input logic         xfer_out_o,
    input logic         illegal_o
);
    function automatic logic is_bcd(input logic [W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o); // R12
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> !(wr_en_o || xfer_in_o || xfer_out_o || illegal_o)); // R12
    AST_MID_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mid_i != 4'd0) |=> (illegal_o && !wr_en_o && !xfer_in_o && !xfer_out_o)); // R2
    AST_HIGH_CODE_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mid_i == 4'd0 && code_i[3]) |=> (illegal_o && !wr_en_o)); // R3
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !wr_en_o); // R2
    AST_ONE_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_in_o, xfer_out_o})); // R4
    AST_OUT_KEEPS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mid_i == 4'd0 && code_i == 4'd1) |=>
        (xfer_out_o && !wr_en_o && result_o == $past(operand_i))); // R5
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mid_i == 4'd0 && code_i == 4'd2) |=> (wr_en_o && result_o == '0)); // R6
    AST_WRITE_IS_BCD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_bcd(operand_i)) |=> (!wr_en_o || is_bcd(result_o))); // R7
endmodule

bind dec_alu dec_alu_checker #(.DIGITS(DIGITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .code_i     (code_i),
    .mid_i      (mid_i),
    .operand_i  (operand_i),
    .done_o     (done_o),
    .result_o   (result_o),
    .wr_en_o    (wr_en_o),
    .xfer_in_o  (xfer_in_o),
    .xfer_out_o (xfer_out_o),
    .illegal_o  (illegal_o)
);

// File: tb/dec_alu_test.sv
`timescale 1ns/1ps
// Sweeping bench for the decimal register ALU at four digits.
module dec_alu_test;
    localparam int DIGITS = 4;
    localparam int W = 4 * DIGITS;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0;
    logic [3:0]   code_i = '0;
    logic [3:0]   mid_i = '0;
    logic [W-1:0] operand_i = '0;
    logic [W-1:0] ext_i = '0;
    logic         done_o;
    logic [W-1:0] result_o;
    logic         wr_en_o, xfer_in_o, xfer_out_o, illegal_o;

    int checks = 0;
    int fails  = 0;

    dec_alu #(.DIGITS(DIGITS)) uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .code_i(code_i),
        .mid_i(mid_i), .operand_i(operand_i), .ext_i(ext_i),
        .done_o(done_o), .result_o(result_o), .wr_en_o(wr_en_o),
        .xfer_in_o(xfer_in_o), .xfer_out_o(xfer_out_o), .illegal_o(illegal_o)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r;
        int x;
        x = v;
        for (int i = 0; i < DIGITS; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    // Compare {done, wr, xin, xout, ill, result} against the expectation.
    task automatic compare(input string tag, input logic [W+4:0] exp);
        logic [W+4:0] got;
        got = {done_o, wr_en_o, xfer_in_o, xfer_out_o, illegal_o, result_o};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    // Apply one request at a falling edge and check one cycle later.
    task automatic do_op(input logic [3:0] c, input logic [3:0] m,
                         input logic [W-1:0] opb, input logic [W-1:0] extb,
                         input string tag, input logic [W+4:0] exp);
        code_i = c; mid_i = m; operand_i = opb; ext_i = extb; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        compare(tag, exp);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stimulus
        string tags [8] = '{"R4", "R5", "R6", "R7", "R8", "R9", "R10", "R11"};
        @(negedge clk);
        @(negedge clk);
        // R1: outputs cleared under reset.
        compare("R1 reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: idle cycle keeps flags low.
        compare("R12 idle", '0);

        // R6 R7 R8 R9 R10 R11: exhaustive arithmetic sweep.
        for (int c = 2; c <= 7; c++) begin
            for (int v = 0; v < 10000; v++) begin
                int e;
                case (c)
                    2: e = 0;
                    3: e = (v + 1) % 10000;
                    4: e = (v + 9999) % 10000;
                    5: e = (10000 - v) % 10000;
                    6: e = (v * 10) % 10000;
                    default: e = v / 10;
                endcase
                do_op(4'(c), 4'd0, to_bcd(v), to_bcd(9999 - v), tags[c],
                      {5'b11000, to_bcd(e)});
            end
        end

        // R4: every legal input word is loaded.
        for (int v = 0; v < 10000; v++) begin
            do_op(4'd0, 4'd0, to_bcd(1234), to_bcd(v), "R4 load",
                  {5'b11100, to_bcd(v)});
        end
        // R4: words with a nibble above 9 are rejected.
        for (int k = 0; k < DIGITS; k++) begin
            for (int n = 10; n < 16; n++) begin
                logic [W-1:0] bad;
                bad = to_bcd(5678);
                bad[4*k +: 4] = 4'(n);
                do_op(4'd0, 4'd0, to_bcd(42), bad, "R4 reject",
                      {5'b10101, {W{1'b0}}});
            end
        end

        // R5: output request returns the operand without a write.
        foreach (tags[i]) begin
            int v;
            v = i * 1249 + 7;
            do_op(4'd1, 4'd0, to_bcd(v), to_bcd(0), "R5 out",
                  {5'b10010, to_bcd(v)});
        end

        // R2: any non-zero third digit is illegal for every code.
        for (int m = 1; m < 16; m++) begin
            for (int c = 0; c < 16; c++) begin
                do_op(4'(c), 4'(m), to_bcd(3141), to_bcd(2718), "R2 mid",
                      {5'b10001, {W{1'b0}}});
            end
        end

        // R3: codes 8 and above are illegal.
        for (int c = 8; c < 16; c++) begin
            do_op(4'(c), 4'd0, to_bcd(9999), to_bcd(1), "R3 code",
                  {5'b10001, {W{1'b0}}});
        end

        // R12: after an idle cycle the flags drop and the result holds.
        do_op(4'd3, 4'd0, to_bcd(4999), to_bcd(0), "R7 inc",
              {5'b11000, to_bcd(5000)});
        @(negedge clk);
        compare("R12 hold", {5'b00000, to_bcd(5000)});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule